// File: doc/BRIEF.md
# Source-Routed Wormhole Mesh Router

This block is a five-port switch for a two-dimensional tile mesh. Four ports face the neighbouring routers (north, east, south, west) and one faces the local tile. Every link carries 36-bit flits: 32 data bits plus type, lane and valid bits. The router does not compute paths. The head flit of each packet carries a list of 3-bit output selections. At each hop the router uses the lowest selection and shifts the list down before passing the head on.

Packets move by wormhole switching. When a head flit wins an output, that output stays with its packet until the tail flit has left. Each input port has two virtual lanes, and each lane has its own small FIFO. Each lane drives a stop signal back upstream when its FIFO is close to full. In the same way, a downstream stop signal holds back any flit of that lane on an output. Outputs are allocated independently, so inputs bound for different outputs all move in the same cycle. Each port also reports when it is quiet, so that power gating can use it.

Top module: `mesh_wh_router`

## Requirements
- R1: After reset, no output flit is valid, every lane stop signal is low and every port reports idle.
- R2: A flit is laid out as: bit 35 valid, bit 34 lane, bits 33:32 kind (00 body, 01 head, 10 tail, 11 single-flit packet), bits 31:0 data. The lane bit and the kind leave the router unchanged.
- R3: The low 3 bits of a head or single flit's data select the output (0 local, 1 north, 2 east, 3 south, 4 west). The forwarded head carries its data shifted right by 3 with zeros filled in. Body and tail data pass unchanged.
- R4: A flit that meets an empty router and a free, unstopped output appears on that output after exactly two rising clock edges counted from the edge that first samples it. It is not yet visible after one edge.
- R5: Once a head leaves an output, that output carries only flits of the same packet until its tail leaves. A competing packet waits and follows after the tail.
- R6: Flits of a lane leave in the order they arrived. None is lost or duplicated, including under random downstream stops.
- R7: Competing heads for one output are served round-robin by input-lane index (2 × port + lane). The search starts just after the index whose tail last left that output, and the pointer moves only when a tail or single flit leaves.
- R8: Inputs bound for distinct outputs are forwarded in the same cycle.
- R9: While the downstream stop bit of a lane is high in a cycle, the flit registered on that output at the following edge is not of that lane.
- R10: A lane's upstream stop signal is high exactly while its FIFO holds DEPTH−2 or more flits (2 with the default depth of 4). Other lanes are unaffected.
- R11: A port's idle flag falls at the edge that samples an arriving flit. It returns high once the port's lanes are empty and its output is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_flit | input | 180 | Incoming flits, 36 bits per port, port p at bits p*36 |
| in_off | output | 10 | Upstream stop per input lane, bit 2*p+lane |
| out_flit | output | 180 | Outgoing flits, 36 bits per port |
| out_off | input | 10 | Downstream stop per output lane, bit 2*p+lane |
| port_idle | output | 5 | Per-port quiet indication |

## Verification
Two events can fall in the same cycle, and both cases are provoked. In the first, a downstream stop rises while the owning packet is mid-flight. In the second, a second head arrives for an output whose current packet's tail is leaving. A directed case holds a lane's stop while its packet queues, then checks that nothing of that lane leaves and that the upstream stop rises at two queued flits. A stress run toggles stops at random on every lane while five ports inject multi-flit packets. It then compares each output lane's captured stream against a per-lane expected queue, so any loss, duplicate or interleave shows up as a mismatch.

// File: rtl/router_pkg.sv
package router_pkg;
    localparam int NPORT  = 5;
    localparam int NLANE  = 2;
    localparam int DATA_W = 32;
    localparam int PORT_W = 3;
    localparam int FLIT_W = DATA_W + 4;

    typedef enum logic [1:0] {
        FT_BODY   = 2'b00,
        FT_HEAD   = 2'b01,
        FT_TAIL   = 2'b10,
        FT_SINGLE = 2'b11
    } ftype_e;

    typedef struct packed {
        logic              valid;
        logic              lane;
        ftype_e            kind;
        logic [DATA_W-1:0] data;
    } flit_t;
endpackage

// File: rtl/router_fifo.sv
module router_fifo
    import router_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int OFF_LVL = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  logic  pop,
    input  flit_t din,
    output flit_t head,
    output logic  empty,
    output logic  off
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    flit_t    mem_q [DEPTH];

    always_comb begin
        s_d = s_q;
        if (push) s_d.wp = s_q.wp + 1'b1;
        if (pop)  s_d.rp = s_q.rp + 1'b1;
        s_d.cnt = s_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[s_q.wp] <= din;
    end

    assign head  = mem_q[s_q.rp];
    assign empty = (s_q.cnt == '0);
    assign off   = (s_q.cnt >= CNT_W'(OFF_LVL));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (s_q.cnt < CNT_W'(DEPTH)) || pop); // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R6
endmodule

// File: rtl/router_out.sv
module router_out
    import router_pkg::*;
#(
    parameter int NIN     = 10,
    parameter int MY_PORT = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  flit_t [NIN-1:0]        heads,
    input  logic  [NIN-1:0]        ready,
    input  logic  [NLANE-1:0]      off_i,
    output logic  [NIN-1:0]        pop,
    output flit_t                  out,
    output logic                   busy
);
    localparam int IDX_W = $clog2(NIN);

    typedef struct packed {
        logic             own;
        logic [IDX_W-1:0] owner;
        logic [IDX_W-1:0] ptr;
        flit_t            out;
    } out_st_t;

    out_st_t          s_d, s_q;
    logic [NIN-1:0]   req;
    logic             found;
    logic             go;
    logic [IDX_W-1:0] win;
    logic [IDX_W-1:0] cur;
    flit_t            f;

    always_comb begin
        s_d     = s_q;
        s_d.out = '0;
        pop     = '0;
        found   = 1'b0;
        win     = '0;
        for (int k = 0; k < NIN; k++) begin
            req[k] = ready[k] && (heads[k].kind inside {FT_HEAD, FT_SINGLE})
                     && (heads[k].data[PORT_W-1:0] == PORT_W'(MY_PORT));
        end
        for (int i = 0; i < NIN; i++) begin
            int j;
            j = int'(s_q.ptr) + i;
            if (j >= NIN) j = j - NIN;
            if (!found && req[j]) begin
                found = 1'b1;
                win   = IDX_W'(j);
            end
        end
        cur = s_q.own ? s_q.owner : win;
        f   = heads[cur];
        go  = (s_q.own || found) && ready[cur] && !off_i[f.lane];
        if (go) begin
            pop[cur] = 1'b1;
            f.valid  = 1'b1;
            if (f.kind inside {FT_HEAD, FT_SINGLE}) f.data = f.data >> PORT_W;
            s_d.out = f;
            if (f.kind inside {FT_TAIL, FT_SINGLE}) begin
                s_d.own = 1'b0;
                s_d.ptr = (cur == IDX_W'(NIN - 1)) ? '0 : cur + 1'b1;
            end else begin
                s_d.own   = 1'b1;
                s_d.owner = cur;
            end
        end else if (!s_q.own && found) begin
            s_d.own   = 1'b1;
            s_d.owner = win;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out  = s_q.out;
    assign busy = s_q.own || s_q.out.valid;

    AST_OFF_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.out.valid |-> (($past(off_i) & (NLANE'(1) << s_q.out.lane)) == '0)); // R9
    AST_WORM_CONT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.out.valid && (s_q.out.kind inside {FT_HEAD, FT_BODY}))
        |=> (!s_q.out.valid || ((s_q.out.kind inside {FT_BODY, FT_TAIL})
                                && s_q.out.lane == $past(s_q.out.lane)))); // R5
    AST_PTR_ON_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.ptr) |-> (s_q.out.valid && (s_q.out.kind inside {FT_TAIL, FT_SINGLE}))); // R7
endmodule

// File: rtl/mesh_wh_router.sv
module mesh_wh_router
    import router_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NPORT*FLIT_W-1:0]   in_flit,
    output logic [NPORT*NLANE-1:0]    in_off,
    output logic [NPORT*FLIT_W-1:0]   out_flit,
    input  logic [NPORT*NLANE-1:0]    out_off,
    output logic [NPORT-1:0]          port_idle
);
    localparam int NIN     = NPORT * NLANE;
    localparam int OFF_LVL = DEPTH - 2;

    typedef struct packed {
        logic [NPORT-1:0] idle;
    } top_st_t;

    flit_t [NPORT-1:0] in_f;
    flit_t [NPORT-1:0] out_f;
    flit_t [NIN-1:0]   heads;
    logic  [NIN-1:0]   empty_v;
    logic  [NIN-1:0]   ready;
    logic  [NIN-1:0]   pop;
    logic  [NIN-1:0]   pop_m [NPORT];
    logic  [NPORT-1:0] pop_by [NIN];
    logic  [NPORT-1:0] busy;
    top_st_t           s_d, s_q;

    assign in_f     = in_flit;
    assign out_flit = out_f;
    assign ready    = ~empty_v;

    for (genvar p = 0; p < NPORT; p++) begin : g_in
        for (genvar l = 0; l < NLANE; l++) begin : g_lane
            localparam int K = p * NLANE + l;
            router_fifo #(.DEPTH(DEPTH), .OFF_LVL(OFF_LVL)) u_fifo (
                .clk   (clk),
                .rst_n (rst_n),
                .push  (in_f[p].valid && (in_f[p].lane == 1'(l))),
                .pop   (pop[K]),
                .din   (in_f[p]),
                .head  (heads[K]),
                .empty (empty_v[K]),
                .off   (in_off[K])
            );
        end
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        router_out #(.NIN(NIN), .MY_PORT(o)) u_out (
            .clk   (clk),
            .rst_n (rst_n),
            .heads (heads),
            .ready (ready),
            .off_i (out_off[o*NLANE +: NLANE]),
            .pop   (pop_m[o]),
            .out   (out_f[o]),
            .busy  (busy[o])
        );
    end

    always_comb begin
        pop = '0;
        for (int k = 0; k < NIN; k++) begin
            for (int o = 0; o < NPORT; o++) pop_by[k][o] = pop_m[o][k];
            pop[k] = |pop_by[k];
        end
        for (int p = 0; p < NPORT; p++) begin
            s_d.idle[p] = !in_f[p].valid && !(|ready[p*NLANE +: NLANE]) && !busy[p];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q.idle <= '1;
        else        s_q      <= s_d;
    end

    assign port_idle = s_q.idle;

    for (genvar k = 0; k < NIN; k++) begin : g_chk
        AST_SINGLE_READER: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(pop_by[k])); // R6
    end
    for (genvar p = 0; p < NPORT; p++) begin : g_idle_chk
        AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
            in_f[p].valid |=> !port_idle[p]); // R11
    end
endmodule

// File: tb/mesh_wh_router_test.sv
module mesh_wh_router_test;
    import router_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [NPORT*FLIT_W-1:0] in_flit = '0;
    logic [NPORT*FLIT_W-1:0] out_flit;
    logic [NPORT*NLANE-1:0]  in_off;
    logic [NPORT*NLANE-1:0]  out_off = '0;
    logic [NPORT-1:0]        port_idle;

    mesh_wh_router uut (
        .clk(clk), .rst_n(rst_n), .in_flit(in_flit), .in_off(in_off),
        .out_flit(out_flit), .out_off(out_off), .port_idle(port_idle)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    flit_t got   [NPORT][$];
    flit_t src   [NPORT][NLANE][$];
    flit_t exp_q [NPORT][NLANE][$];

    task automatic check(string req, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    function automatic flit_t mk(bit lane, ftype_e kind, logic [31:0] d);
        flit_t f;
        f.valid = 1'b1; f.lane = lane; f.kind = kind; f.data = d;
        return f;
    endfunction

    function automatic flit_t fwd(flit_t f);
        flit_t g = f;
        if (f.kind inside {FT_HEAD, FT_SINGLE}) g.data = f.data >> 3;
        return g;
    endfunction

    function automatic flit_t outp(int o);
        return flit_t'(out_flit[o*FLIT_W +: FLIT_W]);
    endfunction

    task automatic drive(int p, flit_t f);
        in_flit[p*FLIT_W +: FLIT_W] = f;
    endtask

    task automatic clear_got();
        for (int o = 0; o < NPORT; o++) got[o].delete();
    endtask

    initial begin
        forever begin
            @(posedge clk); #2;
            for (int o = 0; o < NPORT; o++)
                if (outp(o).valid) got[o].push_back(outp(o));
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic t_reset();
        logic any_valid = 1'b0;
        for (int o = 0; o < NPORT; o++) any_valid |= outp(o).valid;
        check("R1 output valid", 64'(any_valid), 64'd0);
        check("R1 stop signals", 64'(in_off), 64'd0);
        check("R1 idle", 64'(port_idle), 64'h1f);
    endtask

    task automatic t_route();
        flit_t f = mk(1'b0, FT_SINGLE, {29'h0ACE135, 3'd2});
        drive(1, f);
        step();
        drive(1, '0);
        check("R4 not after one edge", 64'(outp(2).valid), 64'd0);
        step();
        check("R3 R2 east output", 64'(outp(2)), 64'(fwd(f)));
        check("R3 other output quiet", 64'(outp(1).valid), 64'd0);
        step();
        check("R4 single cycle", 64'(outp(2).valid), 64'd0);
    endtask

    task automatic t_wormhole();
        flit_t h = mk(1'b1, FT_HEAD, {29'h1234567, 3'd3});
        flit_t b = mk(1'b1, FT_BODY, 32'hB0D1_B0D1);
        flit_t t = mk(1'b1, FT_TAIL, 32'h7A11_7A11);
        flit_t s = mk(1'b0, FT_SINGLE, {29'h0BEEF00, 3'd3});
        clear_got();
        drive(0, h); drive(4, s);
        step(); drive(0, b); drive(4, '0);
        step(); drive(0, t);
        step(); drive(0, '0);
        repeat (8) step();
        check("R5 count", 64'(got[3].size()), 64'd4);
        if (got[3].size() == 4) begin
            check("R5 head first", 64'(got[3][0]), 64'(fwd(h)));
            check("R3 body unchanged", 64'(got[3][1]), 64'(b));
            check("R5 tail third", 64'(got[3][2]), 64'(t));
            check("R5 waiting packet after tail", 64'(got[3][3]), 64'(fwd(s)));
        end
    endtask

    task automatic t_rr();
        flit_t a = mk(1'b0, FT_SINGLE, {29'h0000044, 3'd0});
        flit_t p1 = mk(1'b0, FT_SINGLE, {29'h0000011, 3'd0});
        flit_t p3 = mk(1'b0, FT_SINGLE, {29'h0000033, 3'd0});
        drive(2, a);
        step(); drive(2, '0);
        repeat (5) step();
        clear_got();
        drive(1, p1); drive(3, p3);
        step(); drive(1, '0); drive(3, '0);
        repeat (6) step();
        check("R7 count", 64'(got[0].size()), 64'd2);
        if (got[0].size() == 2) begin
            check("R7 index 6 wins after pointer 5", 64'(got[0][0]), 64'(fwd(p3)));
            check("R7 index 2 follows", 64'(got[0][1]), 64'(fwd(p1)));
        end
    endtask

    task automatic t_parallel();
        flit_t a = mk(1'b0, FT_SINGLE, {29'h00000A1, 3'd1});
        flit_t b = mk(1'b1, FT_SINGLE, {29'h00000B0, 3'd0});
        drive(0, a); drive(1, b);
        step(); drive(0, '0); drive(1, '0);
        step();
        check("R8 north output same cycle", 64'(outp(1)), 64'(fwd(a)));
        check("R8 local output same cycle", 64'(outp(0)), 64'(fwd(b)));
        repeat (3) step();
    endtask

    task automatic t_onoff();
        flit_t h = mk(1'b0, FT_HEAD, {29'h0055AA0, 3'd4});
        flit_t b = mk(1'b0, FT_BODY, 32'hCAFE_0001);
        flit_t t = mk(1'b0, FT_TAIL, 32'hCAFE_0002);
        clear_got();
        out_off[8] = 1'b1;
        drive(2, h);
        step(); drive(2, b);
        step(); drive(2, '0);
        check("R10 stop at two queued", 64'(in_off[4]), 64'd1);
        check("R10 other lane free", 64'(in_off[5]), 64'd0);
        for (int i = 0; i < 3; i++) begin
            step();
            check("R9 stopped lane holds", 64'(outp(4).valid), 64'd0);
        end
        out_off[8] = 1'b0;
        step();
        check("R10 stop released", 64'(in_off[4]), 64'd0);
        drive(2, t);
        step(); drive(2, '0);
        repeat (6) step();
        check("R9 count after release", 64'(got[4].size()), 64'd3);
        if (got[4].size() == 3) begin
            check("R9 head", 64'(got[4][0]), 64'(fwd(h)));
            check("R9 tail", 64'(got[4][2]), 64'(t));
        end
    endtask

    task automatic t_idle();
        repeat (4) step();
        check("R11 all idle when quiet", 64'(port_idle), 64'h1f);
        drive(3, mk(1'b0, FT_SINGLE, {29'h0000777, 3'd1}));
        step(); drive(3, '0);
        check("R11 falls on arrival", 64'(port_idle[3]), 64'd0);
        repeat (6) step();
        check("R11 returns when drained", 64'(port_idle), 64'h1f);
    endtask

    task automatic t_stress();
        int guard = 0;
        bit pending;
        for (int p = 0; p < NPORT; p++) begin
            for (int l = 0; l < NLANE; l++) begin
                for (int n = 0; n < 6; n++) begin
                    int len = 1 + int'($urandom % 4);
                    int dest = (p + 1 + l) % NPORT;
                    logic [31:0] d = $urandom;
                    d[2:0] = 3'(dest);
                    for (int i = 0; i < len; i++) begin
                        flit_t f;
                        if (len == 1)          f = mk(1'(l), FT_SINGLE, d);
                        else if (i == 0)       f = mk(1'(l), FT_HEAD, d);
                        else if (i == len - 1) f = mk(1'(l), FT_TAIL, $urandom);
                        else                   f = mk(1'(l), FT_BODY, $urandom);
                        src[p][l].push_back(f);
                        exp_q[dest][l].push_back(fwd(f));
                    end
                end
            end
        end
        clear_got();
        pending = 1'b1;
        while (pending && guard < 5000) begin
            out_off = 10'($urandom & $urandom);
            pending = 1'b0;
            for (int p = 0; p < NPORT; p++) begin
                bit sent = 1'b0;
                int first = int'($urandom % 2);
                for (int t = 0; t < NLANE; t++) begin
                    int l = (first + t) % NLANE;
                    if (!sent && src[p][l].size() > 0 && !in_off[p*NLANE + l]) begin
                        drive(p, src[p][l].pop_front());
                        sent = 1'b1;
                    end
                end
                if (!sent) drive(p, '0);
                for (int l = 0; l < NLANE; l++) if (src[p][l].size() > 0) pending = 1'b1;
            end
            step();
            guard++;
        end
        for (int p = 0; p < NPORT; p++) drive(p, '0);
        out_off = '0;
        repeat (80) step();
        for (int o = 0; o < NPORT; o++) begin
            for (int l = 0; l < NLANE; l++) begin
                flit_t seen [$];
                int bad = 0;
                foreach (got[o][i]) if (got[o][i].lane == 1'(l)) seen.push_back(got[o][i]);
                check("R6 per-lane flit count", 64'(seen.size()), 64'(exp_q[o][l].size()));
                if (seen.size() == exp_q[o][l].size())
                    foreach (seen[i]) if (seen[i] !== exp_q[o][l][i]) bad++;
                check("R6 per-lane order and content", 64'(bad), 64'd0);
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        t_reset();
        t_route();
        t_wormhole();
        t_rr();
        t_parallel();
        t_onoff();
        t_idle();
        t_stress();
        done = 1'b1;
        finish_run();
    end
endmodule